// File: doc/BRIEF.md
# PLL Unlock Detector with Pulse-Width Qualification

This block watches the phase-error pulse that a PLL phase comparator produces and turns it into an active-low unlock indication for a tri-state pad. A two-bit mode input picks the behaviour. One mode releases the pad. One mode mirrors the error pulse straight onto the pad. Two modes qualify the error by its width and report unlock only when a pulse outlasts a chosen threshold. In the qualified modes the unlock indication is then held for a coarse interval of one to two tick periods. At the default clock the tick period is one millisecond.

The error input is asynchronous to the system clock and passes through a synchronizer before it is measured. Both width thresholds and the tick period are counted in system clock cycles. They are parameters, and their defaults are derived from the clock frequency. The applied mode is registered, and reset clears it to the released mode. Any change of mode wipes the width and hold state, so that the new mode starts clean.

Top module: `pll_unlock_qual`

## Requirements
- R1: With applied mode 2'b00 the pad enable `pad_oe` is 0 and `pad_out` is 1, whatever the error input does.
- R2: With mode 2'b01, `pad_out` is the inverse of `err_in` delayed by two clock edges, with no width qualification and no stretching after the error falls.
- R3: With mode 2'b10, unlock is declared when the synchronized error stays high for more than THR_SHORT consecutive cycles. A pulse of exactly THR_SHORT cycles declares nothing.
- R4: With mode 2'b11 the same rule applies with THR_LONG in place of THR_SHORT.
- R5: Once unlock is declared by a single pulse, `pad_out` stays low for at least TICK_CYCLES+1 and at most 2*TICK_CYCLES consecutive cycles, and then returns high.
- R6: In modes 2'b01, 2'b10 and 2'b11, `pad_oe` is 1. `pad_out` is 0 means unlocked and 1 means locked.
- R7: A further qualifying pulse while the hold is running restarts the hold, so pulses spaced closer than the minimum hold keep `pad_out` low without a gap.
- R8: A change of `mode_in` clears both the running width count and the hold. A held unlock is released on the next cycle, and error time accumulated before the change does not count afterwards.
- R9: Synchronous reset clears the applied mode to 2'b00 (pad released) and clears the synchronizer, width and hold state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| err_in | input | 1 | Phase error pulse from the comparator, active high, asynchronous |
| mode_in | input | 2 | Detection mode: 00 off, 01 raw, 10 narrow threshold, 11 wide threshold |
| pad_out | output | 1 | Value driven on the detect pad, low while unlocked |
| pad_oe | output | 1 | Output enable for the tri-state pad |

## Verification
The hardest situation to reach from the ports is a hold that is restarted before it expires. The tick phase is not visible, so a single pulse cannot tell whether the hold ended or was renewed. The stimulus therefore sends a train of qualifying pulses spaced more tightly than the shortest possible hold, over a window longer than the longest possible single hold, and requires the pad to stay low the whole time. The mode-change clear is reached in a similar way. The error is held high across a mode switch, so that the error time before the switch would exceed the threshold on its own, but the time after the switch stays under it.

// File: rtl/pud_pkg.sv
package pud_pkg;
   typedef enum logic [1:0] {
      DET_OFF    = 2'b00,
      DET_RAW    = 2'b01,
      DET_NARROW = 2'b10,
      DET_WIDE   = 2'b11
   } det_mode_e;
endpackage

// File: rtl/pud_sync.sv
module pud_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pud_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pud_width_meter.sv
module pud_width_meter #(
   parameter int THR_SHORT = 25,
   parameter int THR_LONG  = 50
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic qual,
   input  logic sel_wide,
   input  logic err,
   output logic fire
);
   localparam int WCW = $clog2(THR_LONG + 1);

   logic [WCW-1:0] run_cnt;
   logic [WCW-1:0] thr;

   generate
      if (THR_SHORT < 1 || THR_LONG <= THR_SHORT) begin : g_bad_thr
         $error("pud_width_meter: need 1 <= THR_SHORT < THR_LONG");
      end
   endgenerate

   assign thr  = sel_wide ? WCW'(THR_LONG) : WCW'(THR_SHORT);
   assign fire = qual && err && (run_cnt >= thr);

   always_ff @(posedge clk) begin
      if (rst || clr || !err) run_cnt <= '0;
      else if (run_cnt < thr) run_cnt <= run_cnt + 1'b1;
   end

   // R3 / R4: the run counter saturates and never passes the wide threshold
   assert_run_bound_R3: assert property (@(posedge clk) disable iff (rst)
      run_cnt <= WCW'(THR_LONG));

   // R3: a declaration needs the error to have been high on the previous cycle as well
   assert_fire_needs_run_R3: assert property (@(posedge clk) disable iff (rst)
      fire |-> $past(err));
endmodule

// File: rtl/pud_hold.sv
module pud_hold #(
   parameter int TICK_CYCLES = 50000
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic fire,
   output logic active
);
   localparam int TCW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;

   logic [TCW-1:0] tick_cnt;
   logic           tick;
   logic [1:0]     hold;

   generate
      if (TICK_CYCLES < 2) begin : g_bad_tick
         $error("pud_hold: TICK_CYCLES must be at least 2");
      end
   endgenerate

   assign tick = (tick_cnt == TCW'(TICK_CYCLES - 1));

   always_ff @(posedge clk) begin
      if (rst || tick) tick_cnt <= '0;
      else             tick_cnt <= tick_cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst || clr)             hold <= 2'd0;
      else if (fire)              hold <= 2'd2;
      else if (tick && hold != 0) hold <= hold - 2'd1;
   end

   assign active = (hold != 2'd0);

   // R7: every declaration (re)loads the full hold
   assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
      (fire && !clr) |=> hold == 2'd2);

   // R5: the hold only moves on a tick
   assert_hold_steady_R5: assert property (@(posedge clk) disable iff (rst)
      (!fire && !clr && !tick && hold != 2'd0) |=> $stable(hold));

   // R5: the hold never leaves its two-step range
   assert_hold_range_R5: assert property (@(posedge clk) disable iff (rst)
      hold != 2'd3);
endmodule

// File: rtl/pll_unlock_qual.sv
module pll_unlock_qual
   import pud_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int SYNC_STAGES = 2,
   parameter int THR_SHORT   = CLK_HZ / 2_000_000,
   parameter int THR_LONG    = CLK_HZ / 1_000_000,
   parameter int TICK_CYCLES = CLK_HZ / 1000
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       err_in,
   input  logic [1:0] mode_in,
   output logic       pad_out,
   output logic       pad_oe
);
   det_mode_e mode_r;
   logic      chg;
   logic      err_s;
   logic      qual;
   logic      fire;
   logic      hold_active;

   always_ff @(posedge clk) begin
      if (rst) mode_r <= DET_OFF;
      else     mode_r <= det_mode_e'(mode_in);
   end

   assign chg  = (mode_in != mode_r);
   assign qual = (mode_r == DET_NARROW) || (mode_r == DET_WIDE);

   pud_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (err_in),
      .q   (err_s)
   );

   pud_width_meter #(.THR_SHORT(THR_SHORT), .THR_LONG(THR_LONG)) u_meter (
      .clk      (clk),
      .rst      (rst),
      .clr      (chg),
      .qual     (qual),
      .sel_wide (mode_r == DET_WIDE),
      .err      (err_s),
      .fire     (fire)
   );

   pud_hold #(.TICK_CYCLES(TICK_CYCLES)) u_hold (
      .clk    (clk),
      .rst    (rst),
      .clr    (chg),
      .fire   (fire),
      .active (hold_active)
   );

   always_comb begin
      case (mode_r)
         DET_OFF: pad_out = 1'b1;
         DET_RAW: pad_out = !err_s;
         default: pad_out = !hold_active;
      endcase
   end

   assign pad_oe = (mode_r != DET_OFF);

   // R1: a mode input of 00 releases the pad one edge later
   assert_off_released_R1: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(mode_in) == 2'b00) |-> (!pad_oe && pad_out));

   // R8: a mode change drops any held unlock on the next cycle
   assert_mode_clear_R8: assert property (@(posedge clk) disable iff (rst)
      chg |=> !hold_active);

   // R2: raw mode follows the error input with a two-edge delay
   generate
      if (SYNC_STAGES == 2) begin : g_raw_check
         assert_raw_follow_R2: assert property (@(posedge clk) disable iff (rst)
            (mode_r == DET_RAW && $past(mode_r) == DET_RAW && !$past(rst, 2))
               |-> pad_out == !$past(err_in, 2));
      end
   endgenerate
endmodule

// File: tb/test_pll_unlock_qual.sv
module test_pll_unlock_qual;
   localparam int TICK = 200;
   localparam int THS  = 25;
   localparam int THL  = 50;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       err_in = 1'b0;
   logic [1:0] mode_in = 2'b10;
   logic       pad_out;
   logic       pad_oe;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   pll_unlock_qual #(
      .CLK_HZ(50_000_000), .SYNC_STAGES(2),
      .THR_SHORT(THS), .THR_LONG(THL), .TICK_CYCLES(TICK)
   ) i_pll_unlock_qual (
      .clk(clk), .rst(rst), .err_in(err_in), .mode_in(mode_in),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   // {mode, pulse width, expected pad_out a few cycles after the pulse}
   localparam logic [10:0] VEC [8] = '{
      {2'b10, 8'd25, 1'b1},   // R3 exactly at threshold
      {2'b10, 8'd26, 1'b0},   // R3 one past threshold
      {2'b11, 8'd26, 1'b1},   // R4 narrow width in wide mode
      {2'b11, 8'd50, 1'b1},   // R4 exactly at threshold
      {2'b11, 8'd51, 1'b0},   // R4 one past threshold
      {2'b01, 8'd60, 1'b1},   // R2 no stretch after pulse
      {2'b00, 8'd80, 1'b1},   // R1 released
      {2'b10, 8'd1,  1'b1}    // R3 glitch
   };

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse(input int w);
      err_in = 1'b1;
      repeat (w) step();
      err_in = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int lows;
      int highs;
      @(negedge clk);
      repeat (4) step();
      // R9: applied mode is cleared during reset
      check("R9 oe in reset", pad_oe, 0);
      check("R9 pad in reset", pad_out, 1);
      mode_in = 2'b00;
      rst = 1'b0;
      repeat (3) step();
      err_in = 1'b1;
      repeat (3) step();
      check("R1 oe mode 00", pad_oe, 0);
      check("R1 pad mode 00", pad_out, 1);
      err_in = 1'b0;

      // table walk
      for (int i = 0; i < 8; i++) begin
         mode_in = VEC[i][10:9];
         repeat (3) step();
         pulse(int'(VEC[i][8:1]));
         repeat (4) step();
         check($sformatf("R3/R4 vector %0d pad", i), pad_out, int'(VEC[i][0]));
         check($sformatf("R6 vector %0d oe", i), pad_oe, (VEC[i][10:9] != 2'b00) ? 1 : 0);
         repeat (2 * TICK + 10) step();
      end

      // R2: exact two-edge latency in raw mode
      mode_in = 2'b01;
      repeat (3) step();
      err_in = 1'b1;
      step();
      check("R2 one edge after rise", pad_out, 1);
      step();
      check("R2 two edges after rise", pad_out, 0);
      err_in = 1'b0;
      repeat (2) step();
      check("R2 released after fall", pad_out, 1);

      // R5: single-pulse hold length
      mode_in = 2'b10;
      repeat (3) step();
      lows = 0;
      for (int s = 0; s < 500; s++) begin
         err_in = (s < 26);
         step();
         if (!pad_out) lows++;
      end
      check("R5 hold at least min", (lows >= TICK + 1) ? 1 : 0, 1);
      check("R5 hold at most max", (lows <= 2 * TICK) ? 1 : 0, 1);
      check("R5 released after hold", pad_out, 1);

      // R7: pulse train closer than minimum hold keeps pad low
      highs = 0;
      for (int s = 0; s < 680; s++) begin
         err_in = ((s % 150) < 26) && (s < 476);
         step();
         if (s >= 40 && s < 650 && pad_out) highs++;
      end
      check("R7 high samples during train", highs, 0);
      repeat (2 * TICK + 10) step();

      // R8: mode change releases a held unlock
      pulse(26);
      repeat (4) step();
      check("R8 held before change", pad_out, 0);
      mode_in = 2'b11;
      step();
      check("R8 released after change", pad_out, 1);
      check("R6 oe after change", pad_oe, 1);

      // R8: width count cleared across a mode change
      repeat (3) step();
      err_in = 1'b1;
      repeat (40) step();
      mode_in = 2'b10;
      repeat (20) step();
      err_in = 1'b0;
      repeat (4) step();
      check("R8 width count cleared", pad_out, 1);

      // R9: reset mid-hold clears the hold
      repeat (3) step();
      pulse(26);
      repeat (4) step();
      check("R9 held before reset", pad_out, 0);
      rst = 1'b1;
      step();
      check("R9 oe during reset", pad_oe, 0);
      rst = 1'b0;
      repeat (2) step();
      check("R9 hold cleared", pad_out, 1);
      check("R9 mode reapplied", pad_oe, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule